// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked host read and write an asynchronous static RAM of 65,536 words by 24 bits. The host issues one access at a time over a request/ready handshake: a read/write flag, a 16-bit word address, 24-bit write data and a bank-source select that picks which memory pin carries the top address bit. Read results come back on a data bus with a one-clock valid strobe.

On the memory side the controller drives a pair of chip enables of opposite polarity, active-low output and write enables, fifteen low address lines, two alternative pins for the top address bit plus the source-select pin that chooses between them, and a 24-bit data bus split into an output, an input and a driver enable. The number of wait cycles is derived from the clock period and the memory access time, both given as parameters in nanoseconds. When no access is in progress the memory is parked in standby.

Top module: `sram_ctrl`

## Requirements
- R1: After reset and whenever no access is in progress, the memory is deselected and idle: mem_ce_n_o=1, mem_ce_o=0, mem_oe_n_o=1, mem_we_n_o=1, mem_dq_oe_o=0. The two enables are always complements of each other.
- R2: rdy_o is 1 exactly when the controller is idle. A request is accepted at a rising clock edge where req_i and rdy_o are both 1, and rdy_o is 0 in the following cycle. A request presented while rdy_o is 0 is ignored and causes no memory cycle.
- R3: A read holds the memory selected with mem_oe_n_o=0, mem_we_n_o=1 and mem_dq_oe_o=0 for WAIT cycles. WAIT = ceil(ACCESS_NS / CLK_PERIOD_NS) + 1, which is 2 with the defaults of 10 ns and 20 ns. The first read cycle follows the accepting edge.
- R4: Read data is sampled from mem_dq_i at the edge that ends the last read cycle. rvalid_o is 1 for exactly the one cycle after that edge, with rdata_o holding the sampled word, and rdata_o keeps that word until the next read completes.
- R5: A write runs through one setup cycle (selected, mem_we_n_o=1, mem_oe_n_o=1, mem_dq_oe_o=0), then WAIT cycles with mem_we_n_o=0 and mem_dq_oe_o=1 driving the write data, then one hold cycle (selected, mem_we_n_o=1, drivers still on). Address, source select and write data are stable while mem_we_n_o is 0.
- R6: mem_addr_o carries address bits 14:0. mem_src_o equals the latched bank select. When it is 1, mem_xy_o carries address bit 15 and mem_a15_o is 0; when it is 0, mem_a15_o carries bit 15 and mem_xy_o is 0.
- R7: mem_dq_oe_o and an active mem_oe_n_o (0) never occur in the same cycle.
- R8: mem_oe_n_o never falls in the cycle right after a cycle with mem_dq_oe_o=1, so a read that follows a write is separated from it by at least one released idle cycle.
- R9: mem_oe_n_o is 1 in every cycle where mem_we_n_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| rdy_o | output | 1 | Controller idle, request can be taken |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Word address |
| wdata_i | input | 24 | Write data |
| bank_sel_i | input | 1 | Top address bit source: 1 = mem_xy_o pin, 0 = mem_a15_o pin |
| rdata_o | output | 24 | Read data |
| rvalid_o | output | 1 | Read data valid, one cycle |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_ce_o | output | 1 | Chip enable, active high |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_addr_o | output | 15 | Address bits 14:0 |
| mem_a15_o | output | 1 | Top address bit, direct pin |
| mem_xy_o | output | 1 | Top address bit, alternative pin |
| mem_src_o | output | 1 | Source select for the top address bit |
| mem_dq_o | output | 24 | Data toward the memory |
| mem_dq_i | input | 24 | Data from the memory |
| mem_dq_oe_o | output | 1 | Controller data driver enable |

## Verification
The checker watches on every cycle that idle means standby, that the enable pair stays complementary, that the controller never drives the bus while the memory is asked to output, that a read never starts right after the controller released its drivers, that the unused top-address pin stays low and that the write strobe is framed by a setup and a hold cycle with stable address and data. Only the bench scenarios show that data written through one top-bit pin is read back through the other, that the read word is the one stored at the routed address, that the strobe lasts exactly WAIT cycles, and that a request made while busy leaves the memory untouched.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD
  } state_e;

  // wait cycles: access time rounded up to whole clocks, plus one capture cycle
  function automatic int unsigned wait_cycles(int unsigned access_ns, int unsigned period_ns);
    return (access_ns + period_ns - 1) / period_ns + 1;
  endfunction

endpackage

// File: rtl/sram_ctrl_wait.sv
module sram_ctrl_wait #(
  parameter int unsigned WAIT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic last_o
);
  localparam int unsigned CNT_W = (WAIT > 1) ? $clog2(WAIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_i,
  input  logic   we_i,
  input  logic   last_i,
  output state_e state_o,
  output logic   rdy_o,
  output logic   accept_o,
  output logic   load_o,
  output logic   capture_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req_i) state_d = we_i ? ST_WR_SETUP : ST_RD;
      ST_RD:       if (last_i) state_d = ST_IDLE;
      ST_WR_SETUP: state_d = ST_WR_PULSE;
      ST_WR_PULSE: if (last_i) state_d = ST_WR_HOLD;
      ST_WR_HOLD:  state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o   = state_q;
  assign rdy_o     = (state_q == ST_IDLE);
  assign accept_o  = rdy_o && req_i;
  // restart the wait counter on entry to a timed phase
  assign load_o    = (accept_o && !we_i) || (state_q == ST_WR_SETUP);
  assign capture_o = (state_q == ST_RD) && last_i;

endmodule

// File: rtl/sram_ctrl_bus.sv
module sram_ctrl_bus
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  state_e            state_i,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              ce_n_o,
  output logic              ce_o,
  output logic              oe_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-2:0] addr_lo_o,
  output logic              top_direct_o,
  output logic              top_alt_o,
  output logic              src_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  localparam int unsigned LO_W = ADDR_W - 1;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              sel_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      sel_q  <= 1'b0;
    end else if (accept_i) begin
      addr_q <= addr_i;
      data_q <= wdata_i;
      sel_q  <= sel_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture_i;
      if (capture_i) rdata_q <= dq_i;
    end
  end

  logic sel_act, rd_act, wr_act, drv_act;
  assign sel_act = (state_i != ST_IDLE);
  assign rd_act  = (state_i == ST_RD);
  assign wr_act  = (state_i == ST_WR_PULSE);
  assign drv_act = (state_i == ST_WR_PULSE) || (state_i == ST_WR_HOLD);

  assign ce_n_o  = ~sel_act;
  assign ce_o    = sel_act;
  assign oe_n_o  = ~rd_act;
  assign we_n_o  = ~wr_act;
  assign dq_oe_o = drv_act;
  assign dq_o    = data_q;

  // top bit goes only to the pin the select level names; the other stays low
  assign addr_lo_o    = addr_q[LO_W-1:0];
  assign src_o        = sel_q;
  assign top_alt_o    = sel_q & addr_q[ADDR_W-1];
  assign top_direct_o = ~sel_q & addr_q[ADDR_W-1];

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned DATA_W        = 24,
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned ACCESS_NS     = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  output logic              rdy_o,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              bank_sel_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              mem_ce_n_o,
  output logic              mem_ce_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic [ADDR_W-2:0] mem_addr_o,
  output logic              mem_a15_o,
  output logic              mem_xy_o,
  output logic              mem_src_o,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe_o
);
  localparam int unsigned WAIT = wait_cycles(ACCESS_NS, CLK_PERIOD_NS);

  state_e state;
  logic   accept, load, last, capture;

  sram_ctrl_fsm i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .last_i    (last),
    .state_o   (state),
    .rdy_o     (rdy_o),
    .accept_o  (accept),
    .load_o    (load),
    .capture_o (capture)
  );

  sram_ctrl_wait #(.WAIT(WAIT)) i_wait (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .last_o (last)
  );

  sram_ctrl_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_bus (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .state_i      (state),
    .accept_i     (accept),
    .capture_i    (capture),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .sel_i        (bank_sel_i),
    .dq_i         (mem_dq_i),
    .rdata_o      (rdata_o),
    .rvalid_o     (rvalid_o),
    .ce_n_o       (mem_ce_n_o),
    .ce_o         (mem_ce_o),
    .oe_n_o       (mem_oe_n_o),
    .we_n_o       (mem_we_n_o),
    .addr_lo_o    (mem_addr_o),
    .top_direct_o (mem_a15_o),
    .top_alt_o    (mem_xy_o),
    .src_o        (mem_src_o),
    .dq_o         (mem_dq_o),
    .dq_oe_o      (mem_dq_oe_o)
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              rdy_o,
  input logic              rvalid_o,
  input logic              mem_ce_n_o,
  input logic              mem_ce_o,
  input logic              mem_oe_n_o,
  input logic              mem_we_n_o,
  input logic [ADDR_W-2:0] mem_addr_o,
  input logic              mem_a15_o,
  input logic              mem_xy_o,
  input logic              mem_src_o,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe_o
);

  assert_standby_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> (mem_ce_n_o && !mem_ce_o && mem_oe_n_o && mem_we_n_o && !mem_dq_oe_o));

  assert_ce_pair_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ce_n_o != mem_ce_o);

  assert_accept_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && rdy_o) |=> !rdy_o);

  assert_read_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> (!mem_ce_n_o && mem_we_n_o));

  assert_rvalid_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  assert_we_setup_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_n_o) |-> ($past(!mem_ce_n_o) && $past(mem_oe_n_o) && !$past(mem_dq_oe_o)));

  assert_we_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (mem_dq_oe_o && !mem_ce_n_o));

  assert_we_drive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> mem_dq_oe_o);

  assert_we_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_n_o && $past(!mem_we_n_o)) |->
      ($stable(mem_addr_o) && $stable(mem_dq_o) && $stable(mem_src_o)
       && $stable(mem_xy_o) && $stable(mem_a15_o)));

  assert_route_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_src_o ? !mem_a15_o : !mem_xy_o);

  assert_no_conflict_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_dq_oe_o && !mem_oe_n_o));

  assert_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_oe_n_o) |-> !$past(mem_dq_oe_o));

  assert_oe_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> mem_oe_n_o);

endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .rdy_o       (rdy_o),
  .rvalid_o    (rvalid_o),
  .mem_ce_n_o  (mem_ce_n_o),
  .mem_ce_o    (mem_ce_o),
  .mem_oe_n_o  (mem_oe_n_o),
  .mem_we_n_o  (mem_we_n_o),
  .mem_addr_o  (mem_addr_o),
  .mem_a15_o   (mem_a15_o),
  .mem_xy_o    (mem_xy_o),
  .mem_src_o   (mem_src_o),
  .mem_dq_o    (mem_dq_o),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/test_sram_ctrl.sv
module test_sram_ctrl;
  localparam int CLK_NS   = 20;
  localparam int ACC_NS   = 10;
  localparam int AW       = 16;
  localparam int DW       = 24;
  localparam int WAIT_EXP = (ACC_NS + CLK_NS - 1) / CLK_NS + 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic          we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic          bank_sel_i = 1'b0;
  logic          rdy_o, rvalid_o;
  logic [DW-1:0] rdata_o;
  logic          mem_ce_n_o, mem_ce_o, mem_oe_n_o, mem_we_n_o;
  logic [AW-2:0] mem_addr_o;
  logic          mem_a15_o, mem_xy_o, mem_src_o, mem_dq_oe_o;
  logic [DW-1:0] mem_dq_o, mem_dq_i;

  always #10 clk_i = ~clk_i;

  sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(CLK_NS), .ACCESS_NS(ACC_NS)) i_sram_ctrl (
    .clk_i, .rst_ni, .req_i, .rdy_o, .we_i, .addr_i, .wdata_i, .bank_sel_i,
    .rdata_o, .rvalid_o, .mem_ce_n_o, .mem_ce_o, .mem_oe_n_o, .mem_we_n_o,
    .mem_addr_o, .mem_a15_o, .mem_xy_o, .mem_src_o, .mem_dq_o, .mem_dq_i, .mem_dq_oe_o
  );

  int n_chk = 0;
  int n_err = 0;
  int n_pulses = 0;
  int n_writes = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] init_word(int a);
    return DW'((a * 40503) ^ 32'h003C5A96);
  endfunction

  // memory model, indexed by the address seen on the pins
  logic [DW-1:0] mdl [int];
  logic [DW-1:0] sb  [int];

  function automatic logic [DW-1:0] mdl_rd(int a);
    return mdl.exists(a) ? mdl[a] : init_word(a);
  endfunction

  function automatic logic [DW-1:0] sb_rd(int a);
    return sb.exists(a) ? sb[a] : init_word(a);
  endfunction

  logic [AW-1:0] pin_addr;
  assign pin_addr = {mem_src_o ? mem_xy_o : mem_a15_o, mem_addr_o};

  always @* begin
    if (!mem_ce_n_o && mem_ce_o && !mem_oe_n_o && mem_we_n_o) mem_dq_i = mdl_rd(int'(pin_addr));
    else mem_dq_i = '0;
  end

  always @(posedge mem_we_n_o) begin
    if (!mem_ce_n_o && mem_ce_o) mdl[int'(pin_addr)] = mem_dq_o;
  end

  // per-cycle monitor
  logic prev_dq_oe = 1'b0;
  int   we_low = 0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (!mem_oe_n_o) begin
        chk("R7 bus conflict", 32'(mem_dq_oe_o), 32'd0);
        chk("R8 released cycle before read", 32'(prev_dq_oe), 32'd0);
      end
      if (!mem_we_n_o) begin
        we_low++;
        chk("R9 oe high during strobe", 32'(mem_oe_n_o), 32'd1);
      end else if (we_low != 0) begin
        chk("R5 strobe width", 32'(we_low), 32'(WAIT_EXP));
        n_pulses++;
        we_low = 0;
      end
      prev_dq_oe = mem_dq_oe_o;
    end
  end

  task automatic pin_check(logic [AW-1:0] a, bit s);
    chk("R6 low address", 32'(mem_addr_o), 32'(a[AW-2:0]));
    chk("R6 source pin", 32'(mem_src_o), 32'(s));
    chk("R6 alt top pin", 32'(mem_xy_o), s ? 32'(a[AW-1]) : 32'd0);
    chk("R6 direct top pin", 32'(mem_a15_o), s ? 32'd0 : 32'(a[AW-1]));
  endtask

  task automatic standby_check(string tag);
    chk({tag, " rdy"}, 32'(rdy_o), 32'd1);
    chk({tag, " ce_n"}, 32'(mem_ce_n_o), 32'd1);
    chk({tag, " ce"}, 32'(mem_ce_o), 32'd0);
    chk({tag, " oe_n"}, 32'(mem_oe_n_o), 32'd1);
    chk({tag, " we_n"}, 32'(mem_we_n_o), 32'd1);
    chk({tag, " dq_oe"}, 32'(mem_dq_oe_o), 32'd0);
  endtask

  // called at a negedge with rdy high; returns at a negedge with rdy high
  task automatic do_read(logic [AW-1:0] a, bit s);
    logic [DW-1:0] exp;
    exp = sb_rd(int'(a));
    req_i = 1'b1; we_i = 1'b0; addr_i = a; bank_sel_i = s; wdata_i = DW'($urandom);
    @(negedge clk_i);
    req_i = 1'b0;
    for (int k = 1; k <= WAIT_EXP; k++) begin
      if (k > 1) @(negedge clk_i);
      chk("R3 read oe_n", 32'(mem_oe_n_o), 32'd0);
      chk("R3 read we_n", 32'(mem_we_n_o), 32'd1);
      chk("R3 read ce_n", 32'(mem_ce_n_o), 32'd0);
      chk("R3 read ce", 32'(mem_ce_o), 32'd1);
      chk("R3 read dq_oe", 32'(mem_dq_oe_o), 32'd0);
      chk("R4 rvalid early", 32'(rvalid_o), 32'd0);
      chk("R2 busy", 32'(rdy_o), 32'd0);
      if (k == 1) pin_check(a, s);
    end
    @(negedge clk_i);
    chk("R4 rvalid", 32'(rvalid_o), 32'd1);
    chk("R4 rdata", 32'(rdata_o), 32'(exp));
    standby_check("R1 after read");
    @(negedge clk_i);
    chk("R4 rvalid one cycle", 32'(rvalid_o), 32'd0);
    chk("R4 rdata held", 32'(rdata_o), 32'(exp));
  endtask

  task automatic do_write(logic [AW-1:0] a, bit s, logic [DW-1:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; bank_sel_i = s; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0;
    chk("R5 setup we_n", 32'(mem_we_n_o), 32'd1);
    chk("R5 setup oe_n", 32'(mem_oe_n_o), 32'd1);
    chk("R5 setup dq_oe", 32'(mem_dq_oe_o), 32'd0);
    chk("R5 setup ce_n", 32'(mem_ce_n_o), 32'd0);
    chk("R2 busy", 32'(rdy_o), 32'd0);
    pin_check(a, s);
    for (int k = 1; k <= WAIT_EXP; k++) begin
      @(negedge clk_i);
      chk("R5 strobe we_n", 32'(mem_we_n_o), 32'd0);
      chk("R5 strobe dq_oe", 32'(mem_dq_oe_o), 32'd1);
      chk("R5 strobe data", 32'(mem_dq_o), 32'(d));
    end
    @(negedge clk_i);
    chk("R5 hold we_n", 32'(mem_we_n_o), 32'd1);
    chk("R5 hold dq_oe", 32'(mem_dq_oe_o), 32'd1);
    chk("R5 hold ce_n", 32'(mem_ce_n_o), 32'd0);
    chk("R5 hold data", 32'(mem_dq_o), 32'(d));
    @(negedge clk_i);
    standby_check("R1 after write");
    sb[int'(a)] = d;
    n_writes++;
  endtask

  initial begin
    void'($urandom(32'd5171));
    repeat (3) @(negedge clk_i);
    standby_check("R1 in reset");
    chk("R4 rvalid in reset", 32'(rvalid_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    standby_check("R1 after reset");

    // preloaded words through both top-bit pins
    do_read(16'h8003, 1'b0);
    do_read(16'h8003, 1'b1);
    do_read(16'h0003, 1'b1);
    // write through one pin, read through the other (R6)
    do_write(16'h8010, 1'b1, 24'hA5C3E1);
    do_read(16'h8010, 1'b0);
    do_write(16'h0010, 1'b0, 24'h123456);
    do_read(16'h0010, 1'b1);
    do_read(16'h8010, 1'b1);
    // write directly followed by read of the same word (R8)
    do_write(16'hFFFF, 1'b1, 24'hFFFFFF);
    do_read(16'hFFFF, 1'b0);
    do_write(16'h7FFF, 1'b0, 24'h000000);
    do_write(16'h7FFE, 1'b1, 24'h800001);
    do_read(16'h7FFF, 1'b1);
    do_read(16'h7FFE, 1'b0);

    // request held while busy must be ignored (R2)
    begin
      int p0;
      p0 = n_pulses;
      req_i = 1'b1; we_i = 1'b0; addr_i = 16'h0010; bank_sel_i = 1'b0;
      @(negedge clk_i);
      we_i = 1'b1; addr_i = 16'h8010; wdata_i = 24'hBADBAD;
      for (int k = 2; k <= WAIT_EXP; k++) @(negedge clk_i);
      req_i = 1'b0; we_i = 1'b0;
      @(negedge clk_i);
      chk("R4 rvalid after busy request", 32'(rvalid_o), 32'd1);
      chk("R2 rdata after busy request", 32'(rdata_o), 32'(sb_rd(16'h0010)));
      @(negedge clk_i);
      repeat (3) @(negedge clk_i);
      chk("R2 no write from busy request", 32'(n_pulses), 32'(p0));
      do_read(16'h8010, 1'b1);
    end

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom) & 16'h801F;
      if ($urandom_range(0, 1) == 1) do_write(a, 1'($urandom), DW'($urandom));
      else do_read(a, 1'($urandom));
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 3)) @(negedge clk_i);
    end

    repeat (2) @(negedge clk_i);
    chk("R5 one strobe per write", 32'(n_pulses), 32'(n_writes));
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired R2 actual=busy expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule